// File: doc/BRIEF.md
# Table-Driven Power Sequencing Engine

This block steps a board through its power-up, power-down and fault-recovery sequences. It holds a table of up to 63 states in registers. Each state gives a full pattern for the output enables and three ways to leave the state:

- a sequence jump, taken when a chosen set of inputs reaches the wanted levels;
- a monitor jump, taken when any watched fault input goes to its bad level;
- a timeout jump, taken after a set number of ticks with no other exit.

A monitor entry can instead be marked as a warning. A hit on such an entry then raises a one-cycle interrupt pulse and leaves the state unchanged.

The block evaluates its conditions only on cycles where the slow tick enable is high. A state change therefore takes effect one base tick after its condition becomes true. A host can load table entries through a simple write port at any time. It can also force a jump to any state, and that jump takes effect on the next clock edge whether or not a tick is present. The per-state timeout acts as a watchdog: if an expected input event does not arrive in time, the engine moves to a recovery state. The input flags are expected to be already filtered. All pins are plain level signals sampled on every clock, with no handshake.

Top module: `seq_engine`

## Requirements
- R1: After reset the current state is 0, all output enables are 0, the warning output is 0, and the timeout of state 0 is disabled until state 0 is entered again by a jump.
- R2: On entry to a state, that state's output pattern and tick count are captured. A later write to the entry of the current state does not change `out_en` until the state is entered again, and a jump to the current state counts as an entry.
- R3: On a tick, a state whose sequence mask is nonzero jumps to its sequence target when every input selected by the mask equals the matching bit of the sequence polarity. A mask of zero disables the sequence jump.
- R4: On a tick, the monitor condition holds when any input selected by the monitor mask equals the matching monitor polarity bit. With the warning bit clear, a monitor hit jumps to the monitor target, and it takes priority over the sequence and timeout jumps.
- R5: A state with tick count N (N>0) jumps to its timeout target on the N-th tick after entry, unless a higher-priority jump is taken first. A count of 0 disables the timeout.
- R6: On cycles with `tick` low and no host jump request, the current state and the output enables hold their values.
- R7: With the warning bit set, a monitor hit on a tick raises `warn_irq` for exactly the next cycle, causes no monitor jump, and still lets the sequence or timeout jump of that tick happen.
- R8: A host jump request with a valid target moves to that target on the next edge in any cycle. It overrides every table jump in that cycle.
- R9: Any jump target, from the host or from the table, that is NUM_STATES (63) or above is ignored as if its condition were false.
- R10: When `cfg_we` is high, `cfg_wdata` is written to the entry at `cfg_addr`, and writes to addresses of NUM_STATES or above are dropped. The entry fields, from MSB to LSB, are: outputs[10], seq_mask[10], seq_pol[10], seq_tgt[6], mon_mask[10], mon_pol[10], mon_tgt[6], mon_warn[1], tmo_ticks[16], tmo_tgt[6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_addr | input | 6 | Entry index to write |
| cfg_wdata | input | 85 | Packed entry contents (R10 layout) |
| in_flags | input | 10 | Filtered fault flags and logic inputs |
| tick | input | 1 | Evaluation tick enable |
| sw_jump_req | input | 1 | Host forced-jump request |
| sw_jump_tgt | input | 6 | Host forced-jump target state |
| out_en | output | 10 | Output-enable pattern of the current state |
| cur_state | output | 6 | Current state index |
| warn_irq | output | 1 | One-cycle warning interrupt |

## Verification
The hardest cases to reach are the ones where several exits of a state become true on the same tick. Examples are a monitor hit together with a satisfied sequence condition, a host jump arriving on a tick, and a timeout that expires in the same tick as a warning hit. Another hard case is a self-jump that has to restart a timeout already partly counted down. Directed sequences build each of these on purpose with hand-computed states. A long random phase follows. It uses sparse random masks, targets that include the invalid index, and occasional table rewrites, and it is checked cycle by cycle against a bench model written from the requirements.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SQ_IDX_W = 6;
  localparam int SQ_NIN   = 10;
  localparam int SQ_NOUT  = 10;
  localparam int SQ_TMO_W = 16;

  typedef struct packed {
    logic [SQ_NOUT-1:0]  outs;
    logic [SQ_NIN-1:0]   seq_mask;
    logic [SQ_NIN-1:0]   seq_pol;
    logic [SQ_IDX_W-1:0] seq_tgt;
    logic [SQ_NIN-1:0]   mon_mask;
    logic [SQ_NIN-1:0]   mon_pol;
    logic [SQ_IDX_W-1:0] mon_tgt;
    logic                mon_warn;
    logic [SQ_TMO_W-1:0] tmo_ticks;
    logic [SQ_IDX_W-1:0] tmo_tgt;
  } entry_t;

  localparam int SQ_ENTRY_W = $bits(entry_t);

  function automatic logic idx_ok(input logic [SQ_IDX_W-1:0] i, input int n);
    return int'(i) < n;
  endfunction
endpackage

// File: rtl/seq_cfg_table.sv
module seq_cfg_table
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [SQ_IDX_W-1:0] waddr,
  input  entry_t              wdata,
  input  logic [SQ_IDX_W-1:0] ra,
  output entry_t              rd_a,
  input  logic [SQ_IDX_W-1:0] rb,
  output entry_t              rd_b
);
  entry_t mem [NUM_STATES];

  for (genvar g = 0; g < NUM_STATES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && int'(waddr) == g)
        mem[g] <= wdata;
    end
  end

  assign rd_a = idx_ok(ra, NUM_STATES) ? mem[ra] : '0;
  assign rd_b = idx_ok(rb, NUM_STATES) ? mem[rb] : '0;
endmodule

// File: rtl/seq_timer.sv
module seq_timer
  import seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SQ_TMO_W-1:0] load_val,
  input  logic                tick,
  output logic                expire
);
  logic [SQ_TMO_W-1:0] cnt_q;

  assign expire = tick && (cnt_q == SQ_TMO_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (tick && cnt_q != '0)
      cnt_q <= cnt_q - SQ_TMO_W'(1);
  end
endmodule

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 63
) (
  input  entry_t              ent,
  input  logic [SQ_NIN-1:0]   in_flags,
  input  logic                tick,
  input  logic                tmo_expire,
  input  logic                sw_req,
  input  logic [SQ_IDX_W-1:0] sw_tgt,
  output logic                go,
  output logic [SQ_IDX_W-1:0] go_tgt,
  output logic                warn_hit
);
  logic seq_hit, mon_hit, mon_jump, seq_jump, tmo_jump, sw_jump;

  always_comb begin
    seq_hit  = (ent.seq_mask != '0) &&
               (((in_flags ^ ent.seq_pol) & ent.seq_mask) == '0);
    mon_hit  = ((~(in_flags ^ ent.mon_pol)) & ent.mon_mask) != '0;
    sw_jump  = sw_req && idx_ok(sw_tgt, NUM_STATES);
    mon_jump = tick && mon_hit && !ent.mon_warn && idx_ok(ent.mon_tgt, NUM_STATES);
    seq_jump = tick && seq_hit && idx_ok(ent.seq_tgt, NUM_STATES);
    tmo_jump = tmo_expire && idx_ok(ent.tmo_tgt, NUM_STATES);
    warn_hit = tick && mon_hit && ent.mon_warn;

    go     = 1'b1;
    go_tgt = '0;
    if (sw_jump)       go_tgt = sw_tgt;
    else if (mon_jump) go_tgt = ent.mon_tgt;
    else if (seq_jump) go_tgt = ent.seq_tgt;
    else if (tmo_jump) go_tgt = ent.tmo_tgt;
    else               go     = 1'b0;
  end
endmodule

// File: rtl/seq_engine.sv
module seq_engine
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 63
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SQ_IDX_W-1:0]   cfg_addr,
  input  logic [SQ_ENTRY_W-1:0] cfg_wdata,
  input  logic [SQ_NIN-1:0]     in_flags,
  input  logic                  tick,
  input  logic                  sw_jump_req,
  input  logic [SQ_IDX_W-1:0]   sw_jump_tgt,
  output logic [SQ_NOUT-1:0]    out_en,
  output logic [SQ_IDX_W-1:0]   cur_state,
  output logic                  warn_irq
);
  logic [SQ_IDX_W-1:0] state_q;
  logic [SQ_NOUT-1:0]  out_q;
  logic                warn_q;
  entry_t              cur_ent, nxt_ent;
  logic                go, warn_hit, tmo_expire;
  logic [SQ_IDX_W-1:0] go_tgt;

  seq_cfg_table #(.NUM_STATES(NUM_STATES)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (entry_t'(cfg_wdata)),
    .ra    (state_q),
    .rd_a  (cur_ent),
    .rb    (go_tgt),
    .rd_b  (nxt_ent)
  );

  seq_cond_eval #(.NUM_STATES(NUM_STATES)) u_eval (
    .ent        (cur_ent),
    .in_flags   (in_flags),
    .tick       (tick),
    .tmo_expire (tmo_expire),
    .sw_req     (sw_jump_req),
    .sw_tgt     (sw_jump_tgt),
    .go         (go),
    .go_tgt     (go_tgt),
    .warn_hit   (warn_hit)
  );

  seq_timer u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .load_val (nxt_ent.tmo_ticks),
    .tick     (tick),
    .expire   (tmo_expire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= '0;
      out_q   <= '0;
      warn_q  <= 1'b0;
    end else begin
      warn_q <= warn_hit;
      if (go) begin
        state_q <= go_tgt;
        out_q   <= nxt_ent.outs;
      end
    end
  end

  assign out_en    = out_q;
  assign cur_state = state_q;
  assign warn_irq  = warn_q;
endmodule

// File: rtl/seq_engine_chk.sv
module seq_engine_chk
  import seq_pkg::*;
#(
  parameter int NUM_STATES = 63
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_we,
  input logic [SQ_IDX_W-1:0]   cfg_addr,
  input logic [SQ_ENTRY_W-1:0] cfg_wdata,
  input logic [SQ_NIN-1:0]     in_flags,
  input logic                  tick,
  input logic                  sw_jump_req,
  input logic [SQ_IDX_W-1:0]   sw_jump_tgt,
  input logic [SQ_NOUT-1:0]    out_en,
  input logic [SQ_IDX_W-1:0]   cur_state,
  input logic                  warn_irq
);
  AST_STATE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ok(cur_state, NUM_STATES)); // R9

  AST_IDLE_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_jump_req) |=> $stable(cur_state)); // R6

  AST_IDLE_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_jump_req) |=> $stable(out_en)); // R2

  AST_HOST_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_jump_req && idx_ok(sw_jump_tgt, NUM_STATES)) |=> cur_state == $past(sw_jump_tgt)); // R8

  AST_WARN_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    warn_irq |-> $past(tick)); // R7
endmodule

bind seq_engine seq_engine_chk #(.NUM_STATES(NUM_STATES)) u_chk (.*);

// File: tb/seq_engine_tb.sv
module seq_engine_tb;
  import seq_pkg::*;
  localparam int NS = 63;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cfg_we = 1'b0;
  logic [SQ_IDX_W-1:0]   cfg_addr = '0;
  logic [SQ_ENTRY_W-1:0] cfg_wdata = '0;
  logic [SQ_NIN-1:0]     in_flags = '0;
  logic                  tick = 1'b0;
  logic                  sw_jump_req = 1'b0;
  logic [SQ_IDX_W-1:0]   sw_jump_tgt = '0;
  logic [SQ_NOUT-1:0]    out_en;
  logic [SQ_IDX_W-1:0]   cur_state;
  logic                  warn_irq;

  int errors = 0;
  int checks = 0;

  entry_t              m_tbl [NS];
  logic [SQ_IDX_W-1:0] m_state = '0;
  logic [SQ_NOUT-1:0]  m_out = '0;
  int                  m_cnt = 0;
  logic                m_warn = 1'b0;

  always #10 clk = ~clk;

  seq_engine #(.NUM_STATES(NS)) u_dut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic entry_t mk(input logic [9:0] outs,
                                input logic [9:0] sm, input logic [9:0] sp, input logic [5:0] st,
                                input logic [9:0] mm, input logic [9:0] mp, input logic [5:0] mt,
                                input logic mw, input int tt, input logic [5:0] tg);
    entry_t e;
    e.outs = outs; e.seq_mask = sm; e.seq_pol = sp; e.seq_tgt = st;
    e.mon_mask = mm; e.mon_pol = mp; e.mon_tgt = mt; e.mon_warn = mw;
    e.tmo_ticks = 16'(tt); e.tmo_tgt = tg;
    return e;
  endfunction

  function automatic logic valid(input logic [5:0] t);
    return int'(t) < NS;
  endfunction

  task automatic wr(input logic [5:0] a, input entry_t e);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = e;
    tick = 1'b0; sw_jump_req = 1'b0;
    if (valid(a)) m_tbl[a] = e;
    @(posedge clk); #2;
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  // one clock of stimulus, model from requirements, compare after the edge
  task automatic cyc(input logic [9:0] f, input logic tk, input logic sj, input logic [5:0] st);
    entry_t e;
    logic mh, sh, take;
    logic [5:0] nt;
    string why;
    in_flags = f; tick = tk; sw_jump_req = sj; sw_jump_tgt = st;
    e = m_tbl[m_state];
    mh = ((~(f ^ e.mon_pol)) & e.mon_mask) != '0;
    sh = (e.seq_mask != '0) && (((f ^ e.seq_pol) & e.seq_mask) == '0);
    take = 1'b0; nt = '0; why = "R6";
    if (sj && valid(st)) begin take = 1; nt = st; why = "R8"; end
    else if (tk && mh && !e.mon_warn && valid(e.mon_tgt)) begin take = 1; nt = e.mon_tgt; why = "R4"; end
    else if (tk && sh && valid(e.seq_tgt)) begin take = 1; nt = e.seq_tgt; why = "R3"; end
    else if (tk && m_cnt == 1 && valid(e.tmo_tgt)) begin take = 1; nt = e.tmo_tgt; why = "R5"; end
    m_warn = tk && mh && e.mon_warn;
    if (take) begin
      m_state = nt; m_out = m_tbl[nt].outs; m_cnt = int'(m_tbl[nt].tmo_ticks);
    end else if (tk && m_cnt != 0) m_cnt--;
    @(posedge clk); #2;
    check(why, "state", int'(cur_state), int'(m_state));
    check(why, "out_en", int'(out_en), int'(m_out));
    check("R7", "warn", int'(warn_irq), int'(m_warn));
    @(negedge clk);
  endtask

  task automatic hand(input string req, input int st, input int oe);
    check(req, "hand state", int'(cur_state), st);
    check(req, "hand out_en", int'(out_en), oe);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    for (int i = 0; i < NS; i++) m_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset state", int'(cur_state), 0);
    check("R1", "reset out_en", int'(out_en), 0);
    check("R1", "reset warn", int'(warn_irq), 0);

    wr(0, mk(10'h001, 10'h001, 10'h001, 1, 0, 0, 0, 0, 0, 0));
    wr(1, mk(10'h003, 10'h001, 10'h001, 2, 10'h004, 10'h004, 5, 0, 0, 0));
    wr(2, mk(10'h007, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(3, mk(10'h0F0, 10'h001, 10'h001, 63, 10'h002, 10'h002, 63, 0, 1, 63));
    wr(5, mk(10'h00F, 0, 0, 0, 0, 0, 0, 0, 3, 6));
    wr(6, mk(10'h01F, 10'h010, 10'h010, 2, 10'h008, 10'h008, 0, 1, 0, 0));
    wr(7, mk(10'h3FF, 0, 0, 0, 0, 0, 0, 0, 0, 0)); // written while idle in state 0
    hand("R1", 0, 0);                              // R10 write leaves outputs alone

    cyc(10'h000, 1, 0, 0); hand("R1", 0, 0);        // no timeout in state 0 after reset
    cyc(10'h001, 0, 0, 0); cyc(10'h001, 0, 0, 0);
    hand("R6", 0, 0);                               // condition true but no tick
    cyc(10'h001, 1, 0, 0); hand("R3", 1, 10'h003);
    cyc(10'h005, 1, 0, 0); hand("R4", 5, 10'h00F);  // monitor beats sequence
    cyc(10'h000, 1, 0, 0); cyc(10'h000, 1, 0, 0);
    hand("R5", 5, 10'h00F);
    cyc(10'h000, 0, 0, 0); hand("R6", 5, 10'h00F);
    cyc(10'h000, 1, 0, 0); hand("R5", 6, 10'h01F);  // third tick
    cyc(10'h008, 1, 0, 0);
    check("R7", "warn pulse", int'(warn_irq), 1); hand("R7", 6, 10'h01F);
    cyc(10'h008, 0, 0, 0); check("R7", "warn single", int'(warn_irq), 0);
    cyc(10'h018, 1, 0, 0);                          // warning plus sequence jump
    check("R7", "warn with seq", int'(warn_irq), 1); hand("R7", 2, 10'h007);
    cyc(10'h000, 0, 1, 63); hand("R9", 2, 10'h007);
    cyc(10'h000, 0, 1, 3); hand("R8", 3, 10'h0F0);
    cyc(10'h003, 1, 0, 0); hand("R9", 3, 10'h0F0);  // all targets invalid
    cyc(10'h000, 1, 0, 0); hand("R9", 3, 10'h0F0);
    cyc(10'h000, 0, 1, 2); hand("R8", 2, 10'h007);
    wr(2, mk(10'h2AA, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    cyc(10'h000, 1, 0, 0); hand("R2", 2, 10'h007);
    cyc(10'h000, 0, 1, 2); hand("R2", 2, 10'h2AA);
    cyc(10'h000, 0, 1, 0); hand("R8", 0, 10'h001);
    cyc(10'h001, 1, 1, 5); hand("R8", 5, 10'h00F);  // host beats sequence
    cyc(10'h000, 1, 0, 0); cyc(10'h000, 1, 0, 0);
    cyc(10'h000, 1, 1, 5); hand("R2", 5, 10'h00F);  // self-jump restarts count
    cyc(10'h000, 1, 0, 0); cyc(10'h000, 1, 0, 0);
    hand("R5", 5, 10'h00F);
    cyc(10'h000, 1, 0, 0); hand("R5", 6, 10'h01F);
    wr(6'd63, mk(10'h155, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    cyc(10'h000, 0, 1, 7); hand("R10", 7, 10'h3FF);

    for (int i = 0; i < NS; i++)
      wr(6'(i), mk(10'($urandom), 10'($urandom & $urandom), 10'($urandom), 6'($urandom % 64),
                   10'($urandom & $urandom & $urandom), 10'($urandom), 6'($urandom % 64),
                   ($urandom % 4) == 0, int'($urandom % 5), 6'($urandom % 64)));
    for (int n = 0; n < 4000; n++) begin
      if ((n % 97) == 0)
        wr(6'($urandom % 64), mk(10'($urandom), 10'($urandom & $urandom), 10'($urandom),
                                 6'($urandom % 64), 10'($urandom & $urandom & $urandom),
                                 10'($urandom), 6'($urandom % 64), ($urandom % 4) == 0,
                                 int'($urandom % 5), 6'($urandom % 64)));
      cyc(10'($urandom), ($urandom % 2) == 0, ($urandom % 23) == 0, 6'($urandom % 64));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule